// File: doc/BRIEF.md
# Modem Line Controller with Loopback and Flow Control

This block sits beside the serial shift engines of an asynchronous serial port and owns the six active-low handshake lines. It drives request-to-send and data-terminal-ready. It samples clear-to-send and data-set-ready. It handles ring-indicator and carrier-detect, which can each be driven out or sampled in under one direction setting. Every sampled line passes through a two-flop synchronizer. A status word then reports the current level of each line and one sticky change flag per line. Reading the status word clears the change flags. An interrupt output is high while any change flag is set.

The block also does three jobs for the shift engines. It drops request-to-send automatically when the receive buffer is full. It gates the start of each new transmit character on clear-to-send. It forces the transmit line low for a break request, and if a character is being sent it waits until that character ends. A loopback setting wires every output to its matching input inside the block, holds the external outputs high and ignores the external inputs.

Top module: `mdm_line_unit`

## Requirements
- R1: Outside loopback, with auto-RTS off: rtsNPin = !cfgRts, dtrNPin = !cfgDtr, riNOut = !cfgRi and dcdNOut = !cfgDcd. riOe and dcdOe both equal cfgPinDirOut.
- R2: modemStatus[4] is cts, [5] is dsr, [6] is ri and [7] is dcd. Each reads 1 when its synchronized active-low line is low. Bits [6] and [7] read 0 while cfgPinDirOut is 1.
- R3: modemStatus[0] (cts change), [1] (dsr change) and [3] (dcd change) set on any edge of their synchronized line.
- R4: modemStatus[2] (ring trailing edge) sets only when the synchronized ring line goes from low to high. It does not set on a high-to-low edge.
- R5: A cycle with statusRd high clears bits [3:0] at the next edge, except a bit whose line changes in that same cycle. That bit stays set.
- R6: modemIrq is high exactly while any of modemStatus[3:0] is set.
- R7: With cfgAutoRts high, rtsNPin is 1 whenever rxFillCnt >= FIFO_DEPTH (16). Below that count it is !cfgRts.
- R8: With cfgAutoCts high, txStartOk equals the synchronized cts level. With cfgAutoCts low, txStartOk is 1.
- R9: In loopback (cfgLoop=1), the internal transmit data goes to rxdToShift, request-to-send feeds cts, terminal-ready feeds dsr, and the ring and carrier outputs feed their own inputs. txdPin, rtsNPin, dtrNPin, riNOut and dcdNOut read 1, and the external input pins have no effect.
- R10: When cfgBreak rises while txBusy is low, the transmit line goes to 0 in the same cycle.
- R11: When cfgBreak is raised while txBusy is high, the transmit line follows shiftTxd until txBusy falls. From then on it stays 0 until cfgBreak drops, even if txBusy rises again.
- R12: A change on an external input line shows in the level bits after two clock edges and in the change bits after three.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cfgRts | input | 1 | Request-to-send control bit |
| cfgDtr | input | 1 | Terminal-ready control bit |
| cfgRi | input | 1 | Ring output control bit |
| cfgDcd | input | 1 | Carrier output control bit |
| cfgPinDirOut | input | 1 | 1: ring and carrier pins are outputs |
| cfgLoop | input | 1 | Internal loopback enable |
| cfgAutoRts | input | 1 | Automatic request-to-send from buffer fill |
| cfgAutoCts | input | 1 | Gate transmit start on clear-to-send |
| cfgBreak | input | 1 | Break request |
| statusRd | input | 1 | Status read strobe, clears change bits |
| rxFillCnt | input | CNT_W | Receive buffer occupancy |
| shiftTxd | input | 1 | Serial data from transmit shifter |
| txBusy | input | 1 | Transmit character in progress |
| txStartOk | output | 1 | New transmit character may start |
| rxdToShift | output | 1 | Serial data to receive shifter |
| modemStatus | output | 8 | Levels [7:4], change bits [3:0] |
| modemIrq | output | 1 | Any change bit set |
| txdPin | output | 1 | External transmit line |
| rxdPin | input | 1 | External receive line |
| rtsNPin | output | 1 | Request-to-send, active low |
| dtrNPin | output | 1 | Terminal-ready, active low |
| ctsNPin | input | 1 | Clear-to-send, active low |
| dsrNPin | input | 1 | Data-set-ready, active low |
| riNIn | input | 1 | Ring pin input value |
| riNOut | output | 1 | Ring pin output value |
| riOe | output | 1 | Ring pin output enable |
| dcdNIn | input | 1 | Carrier pin input value |
| dcdNOut | output | 1 | Carrier pin output value |
| dcdOe | output | 1 | Carrier pin output enable |

## Verification
The hardest case to reach from the ports is a line edge that lands in the same cycle as a status read. The edge only becomes visible to the change logic two edges after the pin moves, so the bench first sets one unrelated change bit. It then moves a pin and raises statusRd exactly in the cycle between the second and third edge. The result must show the new bit kept and the old one cleared. The deferred break is a close second: the bench holds txBusy high across the request, drops it, then raises it again to show that the forced low persists.

// File: rtl/mdm_line_pkg.sv
package mdm_line_pkg;
  localparam int NUM_LINES = 4;
  localparam int LINE_CTS = 0;
  localparam int LINE_DSR = 1;
  localparam int LINE_RI  = 2;
  localparam int LINE_DCD = 3;

  // Strobes and routed line values from control to datapath
  typedef struct packed {
    logic ctsN;
    logic dsrN;
    logic riN;
    logic dcdN;
    logic riIsOut;
    logic dcdIsOut;
    logic clrDelta;
  } lineStrobe_t;
endpackage

// File: rtl/mdm_line_ctrl.sv
module mdm_line_ctrl
  import mdm_line_pkg::*;
#(
  parameter int FIFO_DEPTH = 16,
  parameter int CNT_W = $clog2(FIFO_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgRts,
  input  logic             cfgDtr,
  input  logic             cfgRi,
  input  logic             cfgDcd,
  input  logic             cfgPinDirOut,
  input  logic             cfgLoop,
  input  logic             cfgAutoRts,
  input  logic             cfgAutoCts,
  input  logic             cfgBreak,
  input  logic             statusRd,
  input  logic [CNT_W-1:0] rxFillCnt,
  input  logic             shiftTxd,
  input  logic             txBusy,
  input  logic             ctsLvl,
  input  logic             rxdPin,
  input  logic             ctsNPin,
  input  logic             dsrNPin,
  input  logic             riNIn,
  input  logic             dcdNIn,
  output logic             txStartOk,
  output logic             rxdToShift,
  output logic             txdPin,
  output logic             rtsNPin,
  output logic             dtrNPin,
  output logic             riNOut,
  output logic             riOe,
  output logic             dcdNOut,
  output logic             dcdOe,
  output lineStrobe_t      strobes
);
  localparam logic [CNT_W-1:0] FULL_MARK = CNT_W'(FIFO_DEPTH);

  logic fifoFull;
  logic rtsNInt, dtrNInt, riNInt, dcdNInt;
  logic breakHeld, breakNow, txdInt;

  // Flow control: hold request-to-send off while the receive buffer is full
  assign fifoFull = (rxFillCnt >= FULL_MARK);
  assign rtsNInt  = !(cfgRts && !(cfgAutoRts && fifoFull));
  assign dtrNInt  = !cfgDtr;
  assign riNInt   = !cfgRi;
  assign dcdNInt  = !cfgDcd;

  // Break: immediate when idle, otherwise after the current character
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) breakHeld <= 1'b0;
    else       breakHeld <= breakNow;
  end
  assign breakNow = cfgBreak && (breakHeld || !txBusy);
  assign txdInt   = breakNow ? 1'b0 : shiftTxd;

  // External pins, parked high during loopback
  assign txdPin  = cfgLoop ? 1'b1 : txdInt;
  assign rtsNPin = cfgLoop ? 1'b1 : rtsNInt;
  assign dtrNPin = cfgLoop ? 1'b1 : dtrNInt;
  assign riNOut  = cfgLoop ? 1'b1 : riNInt;
  assign dcdNOut = cfgLoop ? 1'b1 : dcdNInt;
  assign riOe    = cfgPinDirOut;
  assign dcdOe   = cfgPinDirOut;

  assign rxdToShift = cfgLoop ? txdInt : rxdPin;
  assign txStartOk  = !cfgAutoCts || ctsLvl;

  // Line routing toward the synchronizers
  always_comb begin
    strobes.ctsN     = cfgLoop ? rtsNInt : ctsNPin;
    strobes.dsrN     = cfgLoop ? dtrNInt : dsrNPin;
    strobes.riN      = cfgLoop ? riNInt  : (cfgPinDirOut ? 1'b1 : riNIn);
    strobes.dcdN     = cfgLoop ? dcdNInt : (cfgPinDirOut ? 1'b1 : dcdNIn);
    strobes.riIsOut  = cfgPinDirOut;
    strobes.dcdIsOut = cfgPinDirOut;
    strobes.clrDelta = statusRd;
  end

  AST_LOOP_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    cfgLoop |-> (txdPin && rtsNPin && dtrNPin && riNOut && dcdNOut)); // R9
  AST_RTS_FULL: assert property (@(posedge clk) disable iff (!rstN)
    (cfgAutoRts && fifoFull && !cfgLoop) |-> rtsNPin); // R7
  AST_BREAK_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    breakNow |=> (!cfgBreak || !txdInt)); // R11
  AST_BREAK_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (cfgBreak && !txBusy) |-> !txdInt); // R10
endmodule

// File: rtl/mdm_line_datapath.sv
module mdm_line_datapath
  import mdm_line_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  lineStrobe_t strobes,
  output logic        ctsLvl,
  output logic [7:0]  modemStatus,
  output logic        modemIrq
);
  logic [NUM_LINES-1:0] rawN, syncN, prevN, chg, rise, setVec, delta;

  assign rawN[LINE_CTS] = strobes.ctsN;
  assign rawN[LINE_DSR] = strobes.dsrN;
  assign rawN[LINE_RI]  = strobes.riN;
  assign rawN[LINE_DCD] = strobes.dcdN;

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_sync
    logic [SYNC_STAGES-1:0] sh;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) sh <= '1;
      else       sh <= {sh[SYNC_STAGES-2:0], rawN[g]};
    end
    assign syncN[g] = sh[SYNC_STAGES-1];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevN <= '1;
    else       prevN <= syncN;
  end

  assign chg  = syncN ^ prevN;
  assign rise = syncN & ~prevN;

  always_comb begin
    setVec           = chg;
    setVec[LINE_RI]  = rise[LINE_RI];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) delta <= '0;
    else       delta <= (strobes.clrDelta ? '0 : delta) | setVec;
  end

  assign ctsLvl = !syncN[LINE_CTS];
  assign modemStatus = {
    !syncN[LINE_DCD] && !strobes.dcdIsOut,
    !syncN[LINE_RI]  && !strobes.riIsOut,
    !syncN[LINE_DSR],
    !syncN[LINE_CTS],
    delta
  };
  assign modemIrq = |delta;

  AST_DELTA_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (|delta && !strobes.clrDelta) |=> ((delta & $past(delta)) == $past(delta))); // R5
  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.clrDelta && setVec == '0) |=> (delta == '0)); // R5
  AST_TERI_RISE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(delta[LINE_RI]) |-> $past(rise[LINE_RI])); // R4
endmodule

// File: rtl/mdm_line_unit.sv
module mdm_line_unit
  import mdm_line_pkg::*;
#(
  parameter int FIFO_DEPTH  = 16,
  parameter int SYNC_STAGES = 2,
  parameter int CNT_W       = $clog2(FIFO_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgRts,
  input  logic             cfgDtr,
  input  logic             cfgRi,
  input  logic             cfgDcd,
  input  logic             cfgPinDirOut,
  input  logic             cfgLoop,
  input  logic             cfgAutoRts,
  input  logic             cfgAutoCts,
  input  logic             cfgBreak,
  input  logic             statusRd,
  input  logic [CNT_W-1:0] rxFillCnt,
  input  logic             shiftTxd,
  input  logic             txBusy,
  output logic             txStartOk,
  output logic             rxdToShift,
  output logic [7:0]       modemStatus,
  output logic             modemIrq,
  output logic             txdPin,
  input  logic             rxdPin,
  output logic             rtsNPin,
  output logic             dtrNPin,
  input  logic             ctsNPin,
  input  logic             dsrNPin,
  input  logic             riNIn,
  output logic             riNOut,
  output logic             riOe,
  input  logic             dcdNIn,
  output logic             dcdNOut,
  output logic             dcdOe
);
  lineStrobe_t strobes;
  logic        ctsLvl;

  mdm_line_ctrl #(.FIFO_DEPTH(FIFO_DEPTH), .CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .cfgRts(cfgRts), .cfgDtr(cfgDtr), .cfgRi(cfgRi), .cfgDcd(cfgDcd),
    .cfgPinDirOut(cfgPinDirOut), .cfgLoop(cfgLoop),
    .cfgAutoRts(cfgAutoRts), .cfgAutoCts(cfgAutoCts), .cfgBreak(cfgBreak),
    .statusRd(statusRd), .rxFillCnt(rxFillCnt),
    .shiftTxd(shiftTxd), .txBusy(txBusy), .ctsLvl(ctsLvl),
    .rxdPin(rxdPin), .ctsNPin(ctsNPin), .dsrNPin(dsrNPin),
    .riNIn(riNIn), .dcdNIn(dcdNIn),
    .txStartOk(txStartOk), .rxdToShift(rxdToShift), .txdPin(txdPin),
    .rtsNPin(rtsNPin), .dtrNPin(dtrNPin), .riNOut(riNOut), .riOe(riOe),
    .dcdNOut(dcdNOut), .dcdOe(dcdOe), .strobes(strobes)
  );

  mdm_line_datapath #(.SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .ctsLvl(ctsLvl),
    .modemStatus(modemStatus), .modemIrq(modemIrq)
  );
endmodule

// File: tb/sim_mdm_line_unit.sv
module sim_mdm_line_unit;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 16;
  localparam int CW = $clog2(DEPTH + 1);

  logic clk = 0, rstN = 0;
  logic cfgRts = 0, cfgDtr = 0, cfgRi = 0, cfgDcd = 0, cfgPinDirOut = 0;
  logic cfgLoop = 0, cfgAutoRts = 0, cfgAutoCts = 0, cfgBreak = 0, statusRd = 0;
  logic [CW-1:0] rxFillCnt = '0;
  logic shiftTxd = 1, txBusy = 0, rxdPin = 1;
  logic ctsNPin = 1, dsrNPin = 1, riNIn = 1, dcdNIn = 1;
  logic txStartOk, rxdToShift, modemIrq, txdPin, rtsNPin, dtrNPin;
  logic riNOut, riOe, dcdNOut, dcdOe;
  logic [7:0] modemStatus;
  int checks = 0, errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mdm_line_unit #(.FIFO_DEPTH(DEPTH)) u0 (
    .clk(clk), .rstN(rstN), .cfgRts(cfgRts), .cfgDtr(cfgDtr), .cfgRi(cfgRi),
    .cfgDcd(cfgDcd), .cfgPinDirOut(cfgPinDirOut), .cfgLoop(cfgLoop),
    .cfgAutoRts(cfgAutoRts), .cfgAutoCts(cfgAutoCts), .cfgBreak(cfgBreak),
    .statusRd(statusRd), .rxFillCnt(rxFillCnt), .shiftTxd(shiftTxd),
    .txBusy(txBusy), .txStartOk(txStartOk), .rxdToShift(rxdToShift),
    .modemStatus(modemStatus), .modemIrq(modemIrq), .txdPin(txdPin),
    .rxdPin(rxdPin), .rtsNPin(rtsNPin), .dtrNPin(dtrNPin), .ctsNPin(ctsNPin),
    .dsrNPin(dsrNPin), .riNIn(riNIn), .riNOut(riNOut), .riOe(riOe),
    .dcdNIn(dcdNIn), .dcdNOut(dcdNOut), .dcdOe(dcdOe)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic clearStatus();
    statusRd = 1; tick(1); statusRd = 0;
  endtask

  task automatic setPins(input logic [3:0] p); // {dcd,ri,dsr,cts} active-low values
    {dcdNIn, riNIn, dsrNPin, ctsNPin} = p;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    tick(3); rstN = 1; tick(1);
    check("reset status", modemStatus, 8'h00);
    check("reset pins", {2'b0, modemIrq, rtsNPin, dtrNPin, riOe, dcdOe, txdPin}, 8'b0001_1001);

    // R1: sweep all control patterns
    for (int i = 0; i < 32; i++) begin
      {cfgPinDirOut, cfgDcd, cfgRi, cfgDtr, cfgRts} = i[4:0];
      #1;
      check("R1 pins", {2'b0, rtsNPin, dtrNPin, riNOut, riOe, dcdNOut, dcdOe},
            {2'b0, !i[0], !i[1], !i[2], i[4], !i[3], i[4]});
    end
    {cfgPinDirOut, cfgDcd, cfgRi, cfgDtr, cfgRts} = '0;
    tick(1);

    // R12: latency of level and change bits
    ctsNPin = 0; tick(1);
    check("R12 level after 1 edge", {7'b0, modemStatus[4]}, 8'd0);
    tick(1);
    check("R12 level after 2 edges", {6'b0, modemStatus[4], modemStatus[0]}, 8'b10);
    tick(1);
    check("R12 change after 3 edges", {7'b0, modemStatus[0]}, 8'd1);
    ctsNPin = 1; tick(3); clearStatus();
    check("R5 read clears", modemStatus, 8'h00);

    // R2: level sweep over all input patterns and both directions
    for (int d = 0; d < 2; d++) begin
      for (int p = 0; p < 16; p++) begin
        cfgPinDirOut = d[0];
        setPins(p[3:0]);
        tick(3);
        check("R2 levels", {4'b0, modemStatus[7:4]},
              {4'b0, !p[3] && d == 0, !p[2] && d == 0, !p[1], !p[0]});
        clearStatus();
      end
    end
    cfgPinDirOut = 0; setPins(4'hF); tick(3); clearStatus();

    // R3 R4 R6: change bits per line, both edge directions
    for (int l = 0; l < 4; l++) begin
      logic [3:0] pv;
      pv = 4'hF; pv[l] = 1'b0;
      setPins(pv); tick(3);
      check("R3 R4 falling", {4'b0, modemStatus[3:0]}, (l == 2) ? 8'h0 : (8'h1 << l));
      check("R6 irq falling", {7'b0, modemIrq}, (l == 2) ? 8'h0 : 8'h1);
      clearStatus();
      setPins(4'hF); tick(3);
      check("R3 R4 rising", {4'b0, modemStatus[3:0]}, 8'h1 << l);
      check("R6 irq rising", {7'b0, modemIrq}, 8'h1);
      clearStatus();
      check("R5 cleared", {4'b0, modemStatus[3:0]}, 8'h0);
    end

    // R5: change in the read cycle survives, older bit is cleared
    dsrNPin = 0; tick(3);
    ctsNPin = 0; tick(2);
    statusRd = 1; tick(1); statusRd = 0;
    check("R5 same-cycle change kept", {4'b0, modemStatus[3:0]}, 8'h1);
    setPins(4'hF); tick(3); clearStatus();

    // R7: auto request-to-send sweep over fill levels
    for (int a = 0; a < 2; a++) begin
      for (int c = 0; c <= DEPTH; c++) begin
        for (int r = 0; r < 2; r++) begin
          cfgAutoRts = a[0]; rxFillCnt = CW'(c); cfgRts = r[0];
          #1;
          check("R7 rts", {7'b0, rtsNPin},
                {7'b0, !(r == 1 && !(a == 1 && c >= DEPTH))});
        end
      end
    end
    cfgAutoRts = 0; cfgRts = 0; rxFillCnt = '0;

    // R8: clear-to-send gate
    cfgAutoCts = 1; ctsNPin = 1; tick(3);
    check("R8 gate closed", {7'b0, txStartOk}, 8'd0);
    ctsNPin = 0; tick(1);
    check("R8 not yet synced", {7'b0, txStartOk}, 8'd0);
    tick(1);
    check("R8 gate open", {7'b0, txStartOk}, 8'd1);
    ctsNPin = 1; tick(3);
    cfgAutoCts = 0; #1;
    check("R8 gate bypass", {7'b0, txStartOk}, 8'd1);
    clearStatus();

    // R9: loopback routing with opposing external inputs
    setPins(4'h0); rxdPin = 0;
    cfgLoop = 1; cfgRts = 1; cfgDtr = 0; cfgRi = 1; cfgDcd = 0;
    tick(3);
    check("R9 loop levels A", {4'b0, modemStatus[7:4]}, 8'b0101);
    check("R9 outputs parked", {3'b0, txdPin, rtsNPin, dtrNPin, riNOut, dcdNOut}, 8'h1F);
    cfgRts = 0; cfgDtr = 1; cfgRi = 0; cfgDcd = 1;
    tick(3);
    check("R9 loop levels B", {4'b0, modemStatus[7:4]}, 8'b1010);
    shiftTxd = 0; #1;
    check("R9 data loop low", {6'b0, rxdToShift, txdPin}, 8'b01);
    shiftTxd = 1; #1;
    check("R9 data loop high", {6'b0, rxdToShift, txdPin}, 8'b11);
    cfgLoop = 0; cfgDtr = 0; cfgDcd = 0; setPins(4'hF); #1;
    check("R9 loop off rxd", {7'b0, rxdToShift}, 8'd0);
    rxdPin = 1; tick(3); clearStatus();

    // R10: break while idle
    cfgBreak = 1; #1;
    check("R10 break immediate", {7'b0, txdPin}, 8'd0);
    cfgBreak = 0; #1;
    check("R10 break released", {7'b0, txdPin}, 8'd1);
    tick(1);

    // R11: break deferred behind a character
    txBusy = 1; cfgBreak = 1; #1;
    check("R11 deferred", {7'b0, txdPin}, 8'd1);
    tick(2);
    check("R11 still deferred", {7'b0, txdPin}, 8'd1);
    txBusy = 0; #1;
    check("R11 after char", {7'b0, txdPin}, 8'd0);
    tick(1);
    txBusy = 1; #1;
    check("R11 held", {7'b0, txdPin}, 8'd0);
    cfgBreak = 0; #1;
    check("R11 released", {7'b0, txdPin}, 8'd1);
    txBusy = 0; tick(2);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule